// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-node directory of a small distributed shared-memory system with `NODES` caching nodes. For every tracked block address it records a directory state (uncached, shared or modified), a bit-vector of the nodes that hold a copy, and the ID of the owning node. A node that misses in its cache sends a read-miss or write-miss request to the controller. The controller then sends point-to-point invalidate, fetch or fetch-and-invalidate messages to the remote holders, waits for every one of them to reply, and grants the block to the requester. Memory data, the network and the caches are not part of the block. Only the message handshakes are modelled.

The controller works on one transaction at a time. It accepts a request only when `req_ready` is high. It drops `req_ready` from the cycle after acceptance until the grant handshake completes. The request, message and grant ports are valid/ready channels. A payload is held stable while `valid` is high and `ready` is low, and it transfers on the first clock edge at which both are high. A port may hold `ready` low for any number of cycles. Replies have no back-pressure: `rsp_valid` is accepted on every clock edge of a pending transaction. A remote node sends exactly one reply for each message it has received, at some point after that message's handshake.

The directory table is updated at the grant handshake. That entry therefore already reflects the new sharers and owner when the next request is looked up.

Top module: `dircoh_dir`

## Requirements
- R1: After reset every block is uncached, `req_ready` is high, and `out_valid` and `grant_valid` are low.
- R2: A read miss to an uncached or shared block is granted without any message, with `grant_excl`=0. The block becomes shared, and the requester is added to its sharers.
- R3: A read miss to a modified block owned by another node sends one fetch message (`out_kind`=1) to the owner. The grant follows that node's reply. The block becomes shared, with the old owner and the requester as sharers.
- R4: A write miss to a shared block sends one invalidate message (`out_kind`=0) to every sharer except the requester. It is granted only after all of them have replied. The block becomes modified, with the requester as sole owner.
- R5: A write miss to a modified block owned by another node sends one fetch-and-invalidate message (`out_kind`=2) to that owner. After the reply, ownership moves to the requester and the block stays modified.
- R6: A write miss to an uncached block is granted at once and makes the requester the owner. Any miss by the node that already owns a modified block is granted at once with no message, and the entry is unchanged.
- R7: Messages for one transaction leave one per handshake, in ascending destination node order. `out_kind`, `out_dest` and `out_addr` hold stable while `out_valid` is high and `out_ready` is low.
- R8: `req_ready` stays low from the cycle after a request is accepted until the grant handshake. The grant fields hold stable while `grant_valid` is high and `grant_ready` is low.
- R9: A reply may arrive in the same cycle as another message handshake, and both are counted. The grant carries the requester ID and address, with `grant_excl`=1 for a write miss and 0 for a read miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_node | input | $clog2(NODES) | Requesting node ID |
| req_addr | input | ADDR_W | Block address |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network takes the message |
| out_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate |
| out_dest | output | $clog2(NODES) | Destination node |
| out_addr | output | ADDR_W | Block address of the message |
| rsp_valid | input | 1 | Reply from a remote node |
| rsp_node | input | $clog2(NODES) | Node that replies |
| grant_valid | output | 1 | Grant to the requester present |
| grant_ready | input | 1 | Requester takes the grant |
| grant_node | output | $clog2(NODES) | Node being granted |
| grant_addr | output | ADDR_W | Granted block address |
| grant_excl | output | 1 | Grant is for a write (exclusive) |

## Verification
Two events can fall in the same cycle: a reply to an earlier message can arrive on the same clock edge as the handshake of the next message. The bench provokes this by answering each message one cycle after its handshake while `out_ready` stays high, so a write miss to a block with several sharers overlaps replies with sends. The bench judges the outcome by requiring that the grant appears only once the number of replies equals the number of expected destinations, and that every destination appears exactly once, in ascending order.

// File: rtl/dircoh_pkg.sv
`timescale 1ns/1ps
package dircoh_pkg;
  typedef enum logic [1:0] {
    BLK_UNCACHED = 2'd0,
    BLK_SHARED   = 2'd1,
    BLK_MODIFIED = 2'd2
  } blk_state_e;

  typedef enum logic [1:0] {
    MSG_INVAL       = 2'd0,
    MSG_FETCH       = 2'd1,
    MSG_FETCH_INVAL = 2'd2
  } msg_kind_e;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_SEND  = 2'd1,
    CT_GRANT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/dircoh_table.sv
`timescale 1ns/1ps
module dircoh_table
  import dircoh_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 4,
  parameter int NID_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output blk_state_e        rd_state,
  output logic [NODES-1:0]  rd_sharers,
  output logic [NID_W-1:0]  rd_owner,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  blk_state_e        wr_state,
  input  logic [NODES-1:0]  wr_sharers,
  input  logic [NID_W-1:0]  wr_owner
);
  localparam int NBLK = 1 << ADDR_W;

  blk_state_e       st_q  [NBLK];
  logic [NODES-1:0] sh_q  [NBLK];
  logic [NID_W-1:0] own_q [NBLK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        st_q[i]  <= BLK_UNCACHED;
        sh_q[i]  <= '0;
        own_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_addr]  <= wr_state;
      sh_q[wr_addr]  <= wr_sharers;
      own_q[wr_addr] <= wr_owner;
    end
  end

  assign rd_state   = st_q[rd_addr];
  assign rd_sharers = sh_q[rd_addr];
  assign rd_owner   = own_q[rd_addr];

  // a modified block has exactly one holder, and that holder is the owner
  assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_state == BLK_MODIFIED) |->
      ($countones(wr_sharers) == 1 && wr_sharers[wr_owner]));

  // a shared block always lists at least one holder
  assert_shared_holder_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_state == BLK_SHARED) |-> (wr_sharers != '0));
endmodule

// File: rtl/dircoh_pick.sv
`timescale 1ns/1ps
module dircoh_pick #(
  parameter int NODES = 4,
  parameter int NID_W = 2
) (
  input  logic [NODES-1:0] pend,
  output logic             any,
  output logic [NID_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = NID_W'(i);
      end
    end
  end
endmodule

// File: rtl/dircoh_ctrl.sv
`timescale 1ns/1ps
module dircoh_ctrl
  import dircoh_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 4,
  parameter int NID_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [NID_W-1:0]  req_node,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [NID_W-1:0]  out_dest,
  output logic [ADDR_W-1:0] out_addr,
  input  logic              rsp_valid,
  input  logic [NID_W-1:0]  rsp_node,
  output logic              grant_valid,
  input  logic              grant_ready,
  output logic [NID_W-1:0]  grant_node,
  output logic [ADDR_W-1:0] grant_addr,
  output logic              grant_excl,
  output logic [ADDR_W-1:0] tb_rd_addr,
  input  blk_state_e        tb_rd_state,
  input  logic [NODES-1:0]  tb_rd_sharers,
  input  logic [NID_W-1:0]  tb_rd_owner,
  output logic              tb_wr_en,
  output logic [ADDR_W-1:0] tb_wr_addr,
  output blk_state_e        tb_wr_state,
  output logic [NODES-1:0]  tb_wr_sharers,
  output logic [NID_W-1:0]  tb_wr_owner,
  output logic [NODES-1:0]  pk_pend,
  input  logic              pk_any,
  input  logic [NID_W-1:0]  pk_idx
);
  ctl_state_e       st_q;
  logic             write_q;
  logic [NID_W-1:0] node_q;
  logic [ADDR_W-1:0] addr_q;
  msg_kind_e        kind_q;
  logic [NODES-1:0] send_q, ack_q;
  logic             upd_q;
  blk_state_e       nst_q;
  logic [NODES-1:0] nsh_q;
  logic [NID_W-1:0] nown_q;

  // decision taken from the request and the current table entry
  logic             accept;
  logic [NODES-1:0] req_bit, own_bit;
  logic [NODES-1:0] d_tgt;
  msg_kind_e        d_kind;
  logic             d_upd;
  blk_state_e       d_st;
  logic [NODES-1:0] d_sh;

  assign tb_rd_addr = req_addr;
  assign req_ready  = (st_q == CT_IDLE);
  assign accept     = req_valid && req_ready;
  assign req_bit    = NODES'(1) << req_node;
  assign own_bit    = NODES'(1) << tb_rd_owner;

  always_comb begin
    d_tgt  = '0;
    d_kind = MSG_INVAL;
    d_upd  = 1'b1;
    d_st   = BLK_SHARED;
    d_sh   = req_bit;
    if (tb_rd_state == BLK_MODIFIED && tb_rd_owner == req_node) begin
      d_upd = 1'b0;
      d_st  = BLK_MODIFIED;
    end else if (!req_write) begin
      d_st = BLK_SHARED;
      if (tb_rd_state == BLK_MODIFIED) begin
        d_tgt  = own_bit;
        d_kind = MSG_FETCH;
        d_sh   = own_bit | req_bit;
      end else if (tb_rd_state == BLK_SHARED) begin
        d_sh = tb_rd_sharers | req_bit;
      end
    end else begin
      d_st = BLK_MODIFIED;
      if (tb_rd_state == BLK_MODIFIED) begin
        d_tgt  = own_bit;
        d_kind = MSG_FETCH_INVAL;
      end else if (tb_rd_state == BLK_SHARED) begin
        d_tgt  = tb_rd_sharers & ~req_bit;
        d_kind = MSG_INVAL;
      end
    end
  end

  // message issue and reply collection
  logic             out_fire, rsp_hit, grant_fire;
  logic [NODES-1:0] send_nxt, ack_nxt;

  assign pk_pend    = send_q;
  assign out_valid  = (st_q == CT_SEND) && pk_any;
  assign out_dest   = pk_idx;
  assign out_kind   = kind_q;
  assign out_addr   = addr_q;
  assign out_fire   = out_valid && out_ready;
  assign rsp_hit    = rsp_valid && (st_q == CT_SEND);
  assign send_nxt   = send_q & ~(out_fire ? (NODES'(1) << pk_idx) : '0);
  assign ack_nxt    = ack_q  & ~(rsp_hit  ? (NODES'(1) << rsp_node) : '0);

  assign grant_valid = (st_q == CT_GRANT);
  assign grant_node  = node_q;
  assign grant_addr  = addr_q;
  assign grant_excl  = write_q;
  assign grant_fire  = grant_valid && grant_ready;

  assign tb_wr_en      = grant_fire && upd_q;
  assign tb_wr_addr    = addr_q;
  assign tb_wr_state   = nst_q;
  assign tb_wr_sharers = nsh_q;
  assign tb_wr_owner   = nown_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= CT_IDLE;
      write_q <= 1'b0;
      node_q  <= '0;
      addr_q  <= '0;
      kind_q  <= MSG_INVAL;
      send_q  <= '0;
      ack_q   <= '0;
      upd_q   <= 1'b0;
      nst_q   <= BLK_UNCACHED;
      nsh_q   <= '0;
      nown_q  <= '0;
    end else begin
      case (st_q)
        CT_IDLE: begin
          if (accept) begin
            write_q <= req_write;
            node_q  <= req_node;
            addr_q  <= req_addr;
            kind_q  <= d_kind;
            send_q  <= d_tgt;
            ack_q   <= d_tgt;
            upd_q   <= d_upd;
            nst_q   <= d_st;
            nsh_q   <= d_sh;
            nown_q  <= req_node;
            st_q    <= (d_tgt == '0) ? CT_GRANT : CT_SEND;
          end
        end
        CT_SEND: begin
          send_q <= send_nxt;
          ack_q  <= ack_nxt;
          if (send_nxt == '0 && ack_nxt == '0) st_q <= CT_GRANT;
        end
        CT_GRANT: begin
          if (grant_fire) st_q <= CT_IDLE;
        end
        default: st_q <= CT_IDLE;
      endcase
    end
  end

  assert_msg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_dest) && $stable(out_kind) && $stable(out_addr)));

  assert_msg_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (send_q[out_dest] && ack_q[out_dest]));

  assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=>
      (grant_valid && $stable(grant_node) && $stable(grant_addr) && $stable(grant_excl)));

  assert_stall_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_grant_after_acks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (ack_q == '0 && !out_valid));
endmodule

// File: rtl/dircoh_dir.sv
`timescale 1ns/1ps
module dircoh_dir
  import dircoh_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 4,
  localparam int NID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [NID_W-1:0]  req_node,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [NID_W-1:0]  out_dest,
  output logic [ADDR_W-1:0] out_addr,
  input  logic              rsp_valid,
  input  logic [NID_W-1:0]  rsp_node,
  output logic              grant_valid,
  input  logic              grant_ready,
  output logic [NID_W-1:0]  grant_node,
  output logic [ADDR_W-1:0] grant_addr,
  output logic              grant_excl
);
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  blk_state_e        rd_state, wr_state;
  logic [NODES-1:0]  rd_sharers, wr_sharers, pend;
  logic [NID_W-1:0]  rd_owner, wr_owner, pick_idx;
  logic              wr_en, pick_any;

  dircoh_table #(.NODES(NODES), .ADDR_W(ADDR_W), .NID_W(NID_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_state(rd_state), .rd_sharers(rd_sharers), .rd_owner(rd_owner),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_state(wr_state),
    .wr_sharers(wr_sharers), .wr_owner(wr_owner)
  );

  dircoh_pick #(.NODES(NODES), .NID_W(NID_W)) u_pick (
    .pend(pend), .any(pick_any), .idx(pick_idx)
  );

  dircoh_ctrl #(.NODES(NODES), .ADDR_W(ADDR_W), .NID_W(NID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_node(req_node), .req_addr(req_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dest(out_dest), .out_addr(out_addr),
    .rsp_valid(rsp_valid), .rsp_node(rsp_node),
    .grant_valid(grant_valid), .grant_ready(grant_ready), .grant_node(grant_node),
    .grant_addr(grant_addr), .grant_excl(grant_excl),
    .tb_rd_addr(rd_addr), .tb_rd_state(rd_state), .tb_rd_sharers(rd_sharers),
    .tb_rd_owner(rd_owner),
    .tb_wr_en(wr_en), .tb_wr_addr(wr_addr), .tb_wr_state(wr_state),
    .tb_wr_sharers(wr_sharers), .tb_wr_owner(wr_owner),
    .pk_pend(pend), .pk_any(pick_any), .pk_idx(pick_idx)
  );
endmodule

// File: tb/dircoh_dir_bench.sv
`timescale 1ns/1ps
module dircoh_dir_bench;
  localparam int NODES  = 4;
  localparam int ADDR_W = 2;
  localparam int NID_W  = 2;
  localparam int NBLK   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [NID_W-1:0] req_node = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, out_valid, grant_valid, grant_excl;
  logic out_ready = 1'b1, grant_ready = 1'b1, rsp_valid = 1'b0;
  logic [1:0] out_kind;
  logic [NID_W-1:0] out_dest, rsp_node = '0, grant_node;
  logic [ADDR_W-1:0] out_addr, grant_addr;

  always #2.5 clk = ~clk;

  dircoh_dir #(.NODES(NODES), .ADDR_W(ADDR_W)) u_dircoh_dir (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_node(req_node), .req_addr(req_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dest(out_dest), .out_addr(out_addr),
    .rsp_valid(rsp_valid), .rsp_node(rsp_node),
    .grant_valid(grant_valid), .grant_ready(grant_ready), .grant_node(grant_node),
    .grant_addr(grant_addr), .grant_excl(grant_excl)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  // reference directory: 0 uncached, 1 shared, 2 modified
  int m_st [NBLK];
  logic [NODES-1:0] m_sh [NBLK];
  int m_own [NBLK];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_req(input bit w, input int n, input int a, input bit bp);
    logic [NODES-1:0] exp_mask, seen;
    int exp_kind, exp_cnt, acks, pend_rsp, cyc, lowest;
    bit done, first, stall_bad;
    string tag;
    exp_mask = '0; exp_kind = 0;
    if (m_st[a] == 2 && m_own[a] == n) tag = "R6";
    else if (!w) begin
      if (m_st[a] == 2) begin tag = "R3"; exp_mask = 4'b1 << m_own[a]; exp_kind = 1; end
      else tag = "R2";
    end else begin
      if (m_st[a] == 2) begin tag = "R5"; exp_mask = 4'b1 << m_own[a]; exp_kind = 2; end
      else if (m_st[a] == 1) begin tag = "R4"; exp_mask = m_sh[a] & ~(4'b1 << n); exp_kind = 0; end
      else tag = "R6";
    end
    exp_cnt = $countones(exp_mask);

    @(negedge clk);
    chk(req_ready === 1'b1, "R8 idle ready", int'(req_ready), 1);
    req_valid = 1'b1; req_write = w; req_node = NID_W'(n); req_addr = ADDR_W'(a);
    grant_ready = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = '0; acks = 0; pend_rsp = -1; cyc = 0; done = 0; first = 1; stall_bad = 0;
    while (!done && cyc < 60) begin
      rsp_valid = 1'b0;
      if (pend_rsp >= 0) begin
        rsp_valid = 1'b1; rsp_node = NID_W'(pend_rsp); acks++; pend_rsp = -1;
      end
      if (req_ready !== 1'b0) stall_bad = 1;
      if (grant_valid === 1'b1) begin
        if (first) begin
          chk(acks == exp_cnt && !rsp_valid, {tag, " R9 grant after all replies"}, acks, exp_cnt);
          chk(seen == exp_mask, {tag, " messages sent"}, int'(seen), int'(exp_mask));
          chk(grant_node == NID_W'(n) && grant_addr == ADDR_W'(a),
              "R9 grant id/addr", int'({grant_node, grant_addr}), int'({NID_W'(n), ADDR_W'(a)}));
          chk(grant_excl === w, "R9 grant_excl", int'(grant_excl), int'(w));
        end
        grant_ready = bp ? !first : 1'b1;
        first = 0;
        if (grant_ready) done = 1;
      end else begin
        out_ready = bp ? cyc[0] : 1'b1;
        if (out_valid === 1'b1) begin
          lowest = -1;
          for (int i = NODES - 1; i >= 0; i--) if (exp_mask[i] && !seen[i]) lowest = i;
          chk(int'(out_dest) == lowest, {tag, " R7 dest order"}, int'(out_dest), lowest);
          chk(int'(out_kind) == exp_kind && out_addr == ADDR_W'(a), {tag, " kind/addr"},
              int'(out_kind), exp_kind);
          if (out_ready) begin
            seen[out_dest] = 1'b1;
            pend_rsp = int'(out_dest);
          end
        end
      end
      @(negedge clk);
      cyc++;
    end
    rsp_valid = 1'b0; grant_ready = 1'b1; out_ready = 1'b1;
    chk(done, {tag, " grant completed"}, int'(done), 1);
    chk(!stall_bad, "R8 stall while busy", int'(stall_bad), 0);
    // update reference
    if (tag == "R6" && m_st[a] == 2) begin
    end else if (!w) begin
      if (m_st[a] == 2) m_sh[a] = (4'b1 << m_own[a]) | (4'b1 << n);
      else m_sh[a] = m_sh[a] | (4'b1 << n);
      m_st[a] = 1;
    end else begin
      m_st[a] = 2; m_own[a] = n; m_sh[a] = 4'b1 << n;
    end
  endtask

  initial begin
    for (int i = 0; i < NBLK; i++) begin m_st[i] = 0; m_sh[i] = '0; m_own[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(out_valid === 1'b0, "R1 no message after reset", int'(out_valid), 0);
    chk(grant_valid === 1'b0, "R1 no grant after reset", int'(grant_valid), 0);
    // directed: three sharers then an invalidating write (replies overlap sends)
    do_req(0, 0, 0, 0);
    do_req(0, 1, 0, 0);
    do_req(0, 3, 0, 0);
    do_req(1, 2, 0, 0);
    do_req(0, 2, 0, 0);
    do_req(1, 1, 0, 1);
    do_req(0, 0, 0, 1);
    // sweep
    for (int rep = 0; rep < 6; rep++)
      for (int a = 0; a < NBLK; a++)
        for (int k = 0; k < 8; k++)
          do_req(((k + rep * a) % 3) == 0, (k * 3 + rep + a) % NODES, a, ((k + rep) % 2) == 1);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule